// File: doc/BRIEF.md
# Capture-to-DMA Transfer Sequencer

This block connects a complementary pair of PWM capture channels to a single DMA request line. Each channel supplies a rising-edge capture value, a falling-edge capture value and a one-cycle latch pulse for each edge. A select input chooses which channel of the pair is serviced. A two-bit mode chooses which edge captures are forwarded. An order bit decides which edge wins when both edges of the selected channel latch in the same cycle.

A forwarded value is placed in one holding register, which drives the DMA data bus, and a request is raised. The request stays up until the DMA acknowledges it. A capture that arrives while a request is still waiting is kept in a one-deep pending slot and issued once the current transfer completes. When two edges latch together, only the edge that comes first in the programmed order is kept, and the other is discarded. A pair enable gates all forwarding.

Top module: `cap_dma_seq`

## Requirements
- R1: When `chan_sel` is 0, only the even channel's latch pulses and values are used. When it is 1, only the odd channel's are used.
- R2: The `cap_mode` encoding is: 0 forwards nothing, 1 forwards rising-edge captures only, 2 forwards falling-edge captures only, and 3 forwards both.
- R3: In mode 3, when the rising and falling latch pulses of the selected channel occur in the same cycle, only one value is loaded. It is the rising value when `rise_first` is 1 and the falling value when `rise_first` is 0. The other value is dropped and never transferred.
- R4: A forwarded capture that arrives while no request is outstanding (and the block is enabled) sets `dma_req` high, with `dma_data` equal to the captured value, in the cycle after the latch pulse.
- R5: While `dma_req` is high and `dma_ack` is low, `dma_req` stays high and `dma_data` does not change.
- R6: In a cycle where `dma_req` and `dma_ack` are both high, the next value is chosen in this order: the pending value if one is held, otherwise a capture forwarded in that same cycle. If neither exists, `dma_req` falls in the next cycle.
- R7: A capture forwarded while a request is waiting (with no acknowledge in that cycle) is stored in the pending slot if the slot is empty, and is issued after the current transfer. If the slot is already full, the capture is dropped.
- R8: While `pair_en` is low, captures are ignored. `dma_req` and the pending slot clear in the next cycle, and `dma_data` keeps its value.
- R9: A synchronous active-low reset clears `dma_req`, the holding register (`dma_data` reads 0) and the pending slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_en | input | 1 | Channel-pair forwarding enable |
| chan_sel | input | 1 | 0 services the even channel, 1 the odd channel |
| cap_mode | input | 2 | Which edges are forwarded (0 none, 1 rise, 2 fall, 3 both) |
| rise_first | input | 1 | 1: rising edge wins an overlap, 0: falling edge wins |
| ev_rise_lat | input | 1 | Even channel rising-edge latch pulse |
| ev_fall_lat | input | 1 | Even channel falling-edge latch pulse |
| ev_rise_val | input | 16 | Even channel rising-edge capture value |
| ev_fall_val | input | 16 | Even channel falling-edge capture value |
| od_rise_lat | input | 1 | Odd channel rising-edge latch pulse |
| od_fall_lat | input | 1 | Odd channel falling-edge latch pulse |
| od_rise_val | input | 16 | Odd channel rising-edge capture value |
| od_fall_val | input | 16 | Odd channel falling-edge capture value |
| dma_ack | input | 1 | DMA acknowledge of the current request |
| dma_req | output | 1 | DMA transfer request |
| dma_data | output | 16 | Holding register contents read by the DMA |

## Verification
The hardest case to reach is a capture arriving in exactly the cycle that an acknowledge lands while the pending slot is already full. In that cycle the pending value must move to the holding register and the new capture must take the slot. Directed sequences build this case on purpose. They raise one capture, add a second while the acknowledge is held low, and then pulse the acknowledge together with a third capture. Random stimulus with acknowledge pulses at roughly half of the cycles, frequent latch pulses and occasional overlaps then revisits the case many times under changing mode, order and select settings.

// File: rtl/cap_dma_pkg.sv
// Shared types for the capture-to-DMA sequencer.
// Assumes nothing beyond a standard SystemVerilog package scope.
package cap_dma_pkg;
    typedef enum logic [1:0] {
        CM_NONE = 2'd0,
        CM_RISE = 2'd1,
        CM_FALL = 2'd2,
        CM_BOTH = 2'd3
    } cap_mode_e;
endpackage

// File: rtl/cap_chan_mux.sv
// Picks the latch pulses and capture values of one channel of the pair.
// Assumes both channels present their values in the same cycle as the pulse.
module cap_chan_mux #(
    parameter int DATA_W = 16
) (
    input  logic              chan_sel,
    input  logic              ev_rise_lat,
    input  logic              ev_fall_lat,
    input  logic [DATA_W-1:0] ev_rise_val,
    input  logic [DATA_W-1:0] ev_fall_val,
    input  logic              od_rise_lat,
    input  logic              od_fall_lat,
    input  logic [DATA_W-1:0] od_rise_val,
    input  logic [DATA_W-1:0] od_fall_val,
    output logic              sel_rise_lat,
    output logic              sel_fall_lat,
    output logic [DATA_W-1:0] sel_rise_val,
    output logic [DATA_W-1:0] sel_fall_val
);
    // Route the serviced channel to the edge picker.
    always_comb begin
        if (chan_sel) begin
            sel_rise_lat = od_rise_lat;
            sel_fall_lat = od_fall_lat;
            sel_rise_val = od_rise_val;
            sel_fall_val = od_fall_val;
        end else begin
            sel_rise_lat = ev_rise_lat;
            sel_fall_lat = ev_fall_lat;
            sel_rise_val = ev_rise_val;
            sel_fall_val = ev_fall_val;
        end
    end
endmodule

// File: rtl/cap_edge_pick.sv
// Applies the edge mode and the overlap order to the selected channel and
// yields at most one capture event per cycle.
// Assumes latch pulses last one cycle.
module cap_edge_pick
    import cap_dma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_en,
    input  cap_mode_e         mode,
    input  logic              rise_first,
    input  logic              rise_lat,
    input  logic              fall_lat,
    input  logic [DATA_W-1:0] rise_val,
    input  logic [DATA_W-1:0] fall_val,
    output logic              evt_v,
    output logic [DATA_W-1:0] evt_val
);
    logic rise_q;
    logic fall_q;

    // Qualify each edge with its mode bit and the pair enable.
    always_comb begin
        rise_q = pair_en && rise_lat && (mode == CM_RISE || mode == CM_BOTH);
        fall_q = pair_en && fall_lat && (mode == CM_FALL || mode == CM_BOTH);
    end

    // Choose one value; on an overlap the edge first in order wins.
    always_comb begin
        evt_v = rise_q || fall_q;
        if (rise_q && fall_q)
            evt_val = rise_first ? rise_val : fall_val;
        else if (rise_q)
            evt_val = rise_val;
        else
            evt_val = fall_val;
    end

    // R2
    mode_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_NONE) |-> !evt_v);

    // R3
    overlap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_en && mode == CM_BOTH && rise_lat && fall_lat)
            |-> (evt_val == (rise_first ? rise_val : fall_val)));
endmodule

// File: rtl/cap_xfer_ctrl.sv
// Holding register, one-deep pending slot and DMA request handshake.
// Assumes the DMA samples the data bus in the cycle it acknowledges.
module cap_xfer_ctrl #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_en,
    input  logic              evt_v,
    input  logic [DATA_W-1:0] evt_val,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic [DATA_W-1:0] dma_data
);
    logic              pend_v;
    logic [DATA_W-1:0] pend_val;

    // Advance the handshake, load the holding register and manage the pending slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req  <= 1'b0;
            dma_data <= '0;
            pend_v   <= 1'b0;
            pend_val <= '0;
        end else if (!pair_en) begin
            dma_req <= 1'b0;
            pend_v  <= 1'b0;
        end else if (!dma_req) begin
            if (evt_v) begin
                dma_data <= evt_val;
                dma_req  <= 1'b1;
            end
        end else if (dma_ack) begin
            if (pend_v) begin
                dma_data <= pend_val;
                pend_v   <= evt_v;
                if (evt_v)
                    pend_val <= evt_val;
            end else if (evt_v) begin
                dma_data <= evt_val;
            end else begin
                dma_req <= 1'b0;
            end
        end else if (evt_v && !pend_v) begin
            pend_v   <= 1'b1;
            pend_val <= evt_val;
        end
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && pair_en) |=> dma_req);

    // R5
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack && pair_en) |=> $stable(dma_data));

    // R8
    dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_en |=> (!dma_req && !pend_v));

    // R4
    idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && pair_en && evt_v) |=> (dma_req && dma_data == $past(evt_val)));

    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && pair_en && !pend_v && !evt_v) |=> !dma_req);
endmodule

// File: rtl/cap_dma_seq.sv
// Top of the capture-to-DMA sequencer: channel select, edge pick, transfer control.
// Assumes all inputs are synchronous to clk.
module cap_dma_seq
    import cap_dma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_en,
    input  logic              chan_sel,
    input  logic [1:0]        cap_mode,
    input  logic              rise_first,
    input  logic              ev_rise_lat,
    input  logic              ev_fall_lat,
    input  logic [DATA_W-1:0] ev_rise_val,
    input  logic [DATA_W-1:0] ev_fall_val,
    input  logic              od_rise_lat,
    input  logic              od_fall_lat,
    input  logic [DATA_W-1:0] od_rise_val,
    input  logic [DATA_W-1:0] od_fall_val,
    input  logic              dma_ack,
    output logic              dma_req,
    output logic [DATA_W-1:0] dma_data
);
    logic              s_rise_lat;
    logic              s_fall_lat;
    logic [DATA_W-1:0] s_rise_val;
    logic [DATA_W-1:0] s_fall_val;
    logic              evt_v;
    logic [DATA_W-1:0] evt_val;

    cap_chan_mux #(.DATA_W(DATA_W)) mux_i (
        .chan_sel     (chan_sel),
        .ev_rise_lat  (ev_rise_lat),
        .ev_fall_lat  (ev_fall_lat),
        .ev_rise_val  (ev_rise_val),
        .ev_fall_val  (ev_fall_val),
        .od_rise_lat  (od_rise_lat),
        .od_fall_lat  (od_fall_lat),
        .od_rise_val  (od_rise_val),
        .od_fall_val  (od_fall_val),
        .sel_rise_lat (s_rise_lat),
        .sel_fall_lat (s_fall_lat),
        .sel_rise_val (s_rise_val),
        .sel_fall_val (s_fall_val)
    );

    cap_edge_pick #(.DATA_W(DATA_W)) pick_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_en    (pair_en),
        .mode       (cap_mode_e'(cap_mode)),
        .rise_first (rise_first),
        .rise_lat   (s_rise_lat),
        .fall_lat   (s_fall_lat),
        .rise_val   (s_rise_val),
        .fall_val   (s_fall_val),
        .evt_v      (evt_v),
        .evt_val    (evt_val)
    );

    cap_xfer_ctrl #(.DATA_W(DATA_W)) xfer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_en  (pair_en),
        .evt_v    (evt_v),
        .evt_val  (evt_val),
        .dma_ack  (dma_ack),
        .dma_req  (dma_req),
        .dma_data (dma_data)
    );

    // R1
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && pair_en && !(chan_sel ? (od_rise_lat || od_fall_lat)
                                           : (ev_rise_lat || ev_fall_lat))) |=> !dma_req);
endmodule

// File: tb/cap_dma_seq_tb.sv
module cap_dma_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pair_en = 1'b0;
    logic        chan_sel = 1'b0;
    logic [1:0]  cap_mode = 2'd0;
    logic        rise_first = 1'b0;
    logic        ev_rise_lat = 1'b0, ev_fall_lat = 1'b0;
    logic [15:0] ev_rise_val = '0, ev_fall_val = '0;
    logic        od_rise_lat = 1'b0, od_fall_lat = 1'b0;
    logic [15:0] od_rise_val = '0, od_fall_val = '0;
    logic        dma_ack = 1'b0;
    logic        dma_req;
    logic [15:0] dma_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    bit          m_req, m_pv;
    logic [15:0] m_hold, m_pval;

    always #2.5 clk = ~clk;

    cap_dma_seq dut_i (
        .clk(clk), .rst_n(rst_n), .pair_en(pair_en), .chan_sel(chan_sel),
        .cap_mode(cap_mode), .rise_first(rise_first),
        .ev_rise_lat(ev_rise_lat), .ev_fall_lat(ev_fall_lat),
        .ev_rise_val(ev_rise_val), .ev_fall_val(ev_fall_val),
        .od_rise_lat(od_rise_lat), .od_fall_lat(od_fall_lat),
        .od_rise_val(od_rise_val), .od_fall_val(od_fall_val),
        .dma_ack(dma_ack), .dma_req(dma_req), .dma_data(dma_data)
    );

    // Forwarded event from the requirements: select, mode, overlap order.
    function automatic bit evt_valid();
        bit r, f;
        r = (chan_sel ? od_rise_lat : ev_rise_lat) && cap_mode[0];
        f = (chan_sel ? od_fall_lat : ev_fall_lat) && cap_mode[1];
        return r || f;
    endfunction

    function automatic logic [15:0] evt_value();
        bit r, f;
        logic [15:0] rv, fv;
        r  = (chan_sel ? od_rise_lat : ev_rise_lat) && cap_mode[0];
        f  = (chan_sel ? od_fall_lat : ev_fall_lat) && cap_mode[1];
        rv = chan_sel ? od_rise_val : ev_rise_val;
        fv = chan_sel ? od_fall_val : ev_fall_val;
        if (r && f) return rise_first ? rv : fv;
        return r ? rv : fv;
    endfunction

    task automatic model_next();
        bit v;
        logic [15:0] val;
        v = evt_valid();
        val = evt_value();
        if (!rst_n) begin
            m_req = 0; m_pv = 0; m_hold = '0; m_pval = '0;
        end else if (!pair_en) begin
            m_req = 0; m_pv = 0;
        end else if (!m_req) begin
            if (v) begin m_hold = val; m_req = 1; end
        end else if (dma_ack) begin
            if (m_pv) begin
                m_hold = m_pval; m_pv = v;
                if (v) m_pval = val;
            end else if (v) m_hold = val;
            else m_req = 0;
        end else if (v && !m_pv) begin
            m_pv = 1; m_pval = val;
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (dma_req !== m_req) begin
            errors++;
            $display("FAIL %s dma_req actual=%0b expected=%0b t=%0t", tag, dma_req, m_req, $time);
        end
        checks++;
        if (dma_data !== m_hold) begin
            errors++;
            $display("FAIL %s dma_data actual=%h expected=%h t=%0t", tag, dma_data, m_hold, $time);
        end
    endtask

    // Inputs were set at a falling edge; advance one clock and compare.
    task automatic step(input string tag);
        model_next();
        @(negedge clk);
        check(tag);
    endtask

    task automatic clr_lat();
        ev_rise_lat = 0; ev_fall_lat = 0; od_rise_lat = 0; od_fall_lat = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        m_req = 0; m_pv = 0; m_hold = '0; m_pval = '0;
        @(negedge clk);
        step("R9 reset");
        step("R9 reset");
        rst_n = 1; pair_en = 1;

        // R1: odd selected, both channels pulse rising
        chan_sel = 1; cap_mode = 2'd1;
        ev_rise_lat = 1; ev_rise_val = 16'h2222;
        od_rise_lat = 1; od_rise_val = 16'h1111;
        step("R1 odd select");
        clr_lat(); dma_ack = 1; step("R6 ack drop");
        dma_ack = 0;
        chan_sel = 0; od_rise_lat = 1; od_rise_val = 16'h3333;
        step("R1 odd ignored when even selected");
        clr_lat();

        // R2: mode 0 nothing; mode 2 only falling
        cap_mode = 2'd0; ev_rise_lat = 1; ev_fall_lat = 1; ev_rise_val = 16'h0A0A; ev_fall_val = 16'h0B0B;
        step("R2 mode none");
        cap_mode = 2'd2; ev_fall_lat = 0;
        step("R2 fall-only ignores rise");
        ev_rise_lat = 0; ev_fall_lat = 1;
        step("R2 fall-only forwards fall");
        clr_lat(); dma_ack = 1; step("R6"); dma_ack = 0;

        // R3: overlap with both orders
        cap_mode = 2'd3; rise_first = 1;
        ev_rise_lat = 1; ev_fall_lat = 1; ev_rise_val = 16'h000B; ev_fall_val = 16'h0003;
        step("R3 overlap rise first");
        clr_lat(); dma_ack = 1; step("R3 other edge dropped"); dma_ack = 0;
        rise_first = 0; ev_rise_lat = 1; ev_fall_lat = 1; ev_rise_val = 16'h00EE; ev_fall_val = 16'h00FF;
        step("R3 overlap fall first");
        clr_lat(); dma_ack = 1; step("R3 other edge dropped"); dma_ack = 0;

        // R4/R5/R7/R6: pend, full-slot drop, ack with new event
        ev_rise_lat = 1; ev_rise_val = 16'h0101; step("R4 idle load");
        ev_rise_lat = 0; ev_fall_lat = 1; ev_fall_val = 16'h0202; step("R7 pend store");
        ev_fall_lat = 0; ev_rise_lat = 1; ev_rise_val = 16'h0303; step("R7 slot full drop");
        clr_lat(); step("R5 hold");
        ev_fall_lat = 1; ev_fall_val = 16'h0404; dma_ack = 1; step("R6 pending promoted");
        clr_lat(); step("R6 new event in slot");
        step("R6 promote new"); dma_ack = 0;
        ev_rise_lat = 1; ev_rise_val = 16'h0505; dma_ack = 1; step("R6");
        clr_lat(); dma_ack = 0; step("R5");

        // R8: disable clears, ignores events
        ev_rise_lat = 1; ev_rise_val = 16'h0606; step("R7 pend store");
        clr_lat(); pair_en = 0; step("R8 disable clears");
        ev_rise_lat = 1; ev_rise_val = 16'h0707; step("R8 ignored");
        clr_lat(); pair_en = 1; step("R8 pending gone");
        step("R8 pending gone");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            pair_en    = ($urandom % 40) != 0;
            if (($urandom % 16) == 0) chan_sel = $urandom;
            if (($urandom % 8) == 0) cap_mode = $urandom;
            if (($urandom % 8) == 0) rise_first = $urandom;
            ev_rise_lat = ($urandom % 3) == 0; ev_fall_lat = ($urandom % 3) == 0;
            od_rise_lat = ($urandom % 3) == 0; od_fall_lat = ($urandom % 3) == 0;
            ev_rise_val = $urandom; ev_fall_val = $urandom;
            od_rise_val = $urandom; od_fall_val = $urandom;
            dma_ack = m_req && (($urandom % 2) == 0);
            step("R2 R3 R5 R6 R7 random");
        end
        clr_lat(); dma_ack = 0;
        rst_n = 0; step("R9 reset again");
        finish_run();
    end
endmodule